// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block turns a fast reference clock into a steady one-microsecond tick and counts those ticks in a free-running up-counter. The reference may run at 12, 13, 19.2 or 26 MHz. The prescale ratio is not a plain integer divider. It is a numerator/denominator pair: on every reference cycle the numerator is added to a phase accumulator. When the accumulator reaches the denominator, the denominator is taken back out of it and one tick is emitted. A ratio such as 5 ticks per 96 cycles for a 19.2 MHz reference is therefore exact on average and never drifts.

Software sets the ratio through a small register window. The same window lets it read the microsecond count and stop the timebase with a freeze control. The ratio register can be read back in full, so it can be saved before a power-down and written again afterwards. The single-cycle tick is also driven out as a port so that other timers can step on it, and the count is driven out as a port as well.

Top module: `usec_timebase`

## Requirements
- R1: After synchronous reset the count is 0, the freeze bit is 0, the tick output is low and the ratio register reads 0x0000000b.
- R2: The ratio register holds the denominator minus one in bits [7:0] and the numerator minus one in bits [15:8]. On each reference cycle that is not frozen and not a ratio write, the numerator is added to the accumulator. When the sum reaches the denominator, the denominator is subtracted from it, the tick output pulses high for one cycle and the count rises by one. Over N such cycles after a ratio write, the count therefore rises by floor(N*numerator/denominator). For example, 0x045f gives 50 ticks in 960 cycles, 0x000b gives 100 ticks in 1200 cycles, 0x000c gives 100 in 1300 and 0x0019 gives 100 in 2600.
- R3: The count is COUNT_W bits wide (32 by default) and wraps from all ones to zero.
- R4: Register offsets are 0x10 for the count (read only), 0x14 for the ratio and 0x4c for the freeze control (bit 0). The ratio register keeps bits [15:0] of a write, and its upper bits read as zero. Any other offset reads as zero.
- R5: While the freeze bit is 1, the accumulator and the count hold their values and no tick is emitted. Once the bit is cleared, counting resumes from the held phase.
- R6: A write to the ratio register clears the accumulator, and that cycle produces no tick. With ratio 0x000b, the first tick after the write comes on the 12th following cycle.
- R7: Writes to the count offset or to an unmapped offset change no register.
- R8: The count output port always equals the value read at offset 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr (combinational) |
| usec_tick | output | 1 | One-cycle pulse per microsecond |
| usec_count | output | COUNT_W (32) | Free-running microsecond count |

## Verification
The bound checker checks four things on every cycle: the count only ever steps by one modulo its width, every tick coincides with such a step, a frozen cycle holds the accumulator and count, and a ratio write leaves the accumulator at zero with no tick. It also checks that the accumulator stays below the denominator. The exact long-run tick rates for the four reference ratios, the register map, the handling of ignored writes and the 12-cycle restart after a ratio write can only be shown by the bench's scenarios. These are compared against a behavioural model on every clock. Wrap-around is exercised on a second, narrow instance with a 10-bit count.

// File: rtl/usec_pkg.sv
package usec_pkg;

   typedef enum logic [1:0] {
      REG_NONE   = 2'd0,
      REG_COUNT  = 2'd1,
      REG_RATIO  = 2'd2,
      REG_FREEZE = 2'd3
   } reg_sel_e;

   function automatic int unsigned lanes_for(input int unsigned width, input int unsigned lane);
      return (width + lane - 1) / lane;
   endfunction

endpackage

// File: rtl/usec_regs.sv
module usec_regs
   import usec_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned FIELD_W = 8,
   parameter int unsigned COUNT_W = 32,
   parameter logic [ADDR_W-1:0] OFS_COUNT  = 8'h10,
   parameter logic [ADDR_W-1:0] OFS_RATIO  = 8'h14,
   parameter logic [ADDR_W-1:0] OFS_FREEZE = 8'h4c,
   parameter logic [2*FIELD_W-1:0] RATIO_RESET = 16'h000b
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   bus_we,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [DATA_W-1:0]      bus_wdata,
   input  logic [COUNT_W-1:0]     count_i,
   output logic [DATA_W-1:0]      bus_rdata,
   output logic [2*FIELD_W-1:0]   ratio_o,
   output logic                   freeze_o,
   output logic                   ratio_wr_o
);

   localparam int unsigned RATIO_W = 2 * FIELD_W;

   initial begin
      if (RATIO_W > DATA_W) $fatal(1, "ratio fields exceed data width");
      if (COUNT_W > DATA_W) $fatal(1, "count exceeds data width");
      if (OFS_COUNT == OFS_RATIO || OFS_COUNT == OFS_FREEZE || OFS_RATIO == OFS_FREEZE)
         $fatal(1, "register offsets must differ");
   end

   reg_sel_e             sel;
   logic [RATIO_W-1:0]   ratio_q;
   logic                 freeze_q;

   always_comb begin
      if (bus_addr == OFS_COUNT)       sel = REG_COUNT;
      else if (bus_addr == OFS_RATIO)  sel = REG_RATIO;
      else if (bus_addr == OFS_FREEZE) sel = REG_FREEZE;
      else                             sel = REG_NONE;
   end

   assign ratio_wr_o = bus_we && (sel == REG_RATIO);

   always_ff @(posedge clk) begin
      if (rst) begin
         ratio_q  <= RATIO_RESET;
         freeze_q <= 1'b0;
      end else if (bus_we) begin
         case (sel)
            REG_RATIO:  ratio_q  <= bus_wdata[RATIO_W-1:0];
            REG_FREEZE: freeze_q <= bus_wdata[0];
            default:    ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (sel)
         REG_COUNT:  bus_rdata[COUNT_W-1:0] = count_i;
         REG_RATIO:  bus_rdata[RATIO_W-1:0] = ratio_q;
         REG_FREEZE: bus_rdata[0]           = freeze_q;
         default:    bus_rdata = '0;
      endcase
   end

   assign ratio_o  = ratio_q;
   assign freeze_o = freeze_q;

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/usec_accum.sv
module usec_accum #(
   parameter int unsigned FIELD_W    = 8,
   parameter bit          USE_BORROW = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [2*FIELD_W-1:0]  ratio_i,
   input  logic                  freeze_i,
   input  logic                  clear_i,
   output logic                  adv_o,
   output logic                  tick_o,
   output logic [FIELD_W:0]      acc_o,
   output logic [FIELD_W:0]      den_o
);

   localparam int unsigned ACC_W = FIELD_W + 1;
   localparam int unsigned SUM_W = FIELD_W + 2;

   initial begin
      if (FIELD_W < 1) $fatal(1, "FIELD_W must be at least 1");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] num;
   logic [ACC_W-1:0] den;
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] rem;
   logic             hit;
   logic             tick_q;

   assign num = {1'b0, ratio_i[2*FIELD_W-1:FIELD_W]} + ACC_W'(1);
   assign den = {1'b0, ratio_i[FIELD_W-1:0]} + ACC_W'(1);
   assign sum = {1'b0, acc_q} + {1'b0, num};
   assign rem = sum - {1'b0, den};

   generate
      if (USE_BORROW) begin : g_borrow
         logic [SUM_W:0] diff;
         assign diff = {1'b0, sum} - {2'b00, den};
         assign hit  = ~diff[SUM_W];
      end else begin : g_compare
         assign hit = (sum >= {1'b0, den});
      end
   endgenerate

   assign adv_o = hit && !freeze_i && !clear_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= adv_o;
         if (clear_i)
            acc_q <= '0;
         else if (!freeze_i)
            acc_q <= hit ? rem[ACC_W-1:0] : sum[ACC_W-1:0];
      end
   end

   assign tick_o = tick_q;
   assign acc_o  = acc_q;
   assign den_o  = den;

endmodule

// File: rtl/usec_count.sv
module usec_count
   import usec_pkg::*;
#(
   parameter int unsigned COUNT_W = 32,
   parameter int unsigned LANE_W  = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               inc_i,
   output logic [COUNT_W-1:0] count_o
);

   localparam int unsigned NLANES = lanes_for(COUNT_W, LANE_W);

   initial begin
      if (LANE_W < 1) $fatal(1, "LANE_W must be at least 1");
      if (COUNT_W % LANE_W != 0) $fatal(1, "COUNT_W must be a multiple of LANE_W");
   end

   logic [NLANES:0] carry;
   assign carry[0] = inc_i;

   generate
      for (genvar i = 0; i < NLANES; i++) begin : g_lane
         logic [LANE_W-1:0] lane_q;
         assign carry[i+1] = carry[i] && (&lane_q);
         always_ff @(posedge clk) begin
            if (rst)
               lane_q <= '0;
            else if (carry[i])
               lane_q <= lane_q + LANE_W'(1);
         end
         assign count_o[i*LANE_W +: LANE_W] = lane_q;
      end
   endgenerate

   logic unused_carry;
   assign unused_carry = carry[NLANES];

endmodule

// File: rtl/usec_timebase.sv
module usec_timebase #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FIELD_W    = 8,
   parameter int unsigned COUNT_W    = 32,
   parameter int unsigned LANE_W     = 8,
   parameter bit          USE_BORROW = 1'b0,
   parameter logic [2*FIELD_W-1:0] RATIO_RESET = 16'h000b
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               usec_tick,
   output logic [COUNT_W-1:0] usec_count
);

   logic [2*FIELD_W-1:0] ratio_w;
   logic                 frz_w;
   logic                 ratio_wr_w;
   logic                 adv_w;
   logic [FIELD_W:0]     acc_w;
   logic [FIELD_W:0]     den_w;

   usec_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W), .COUNT_W(COUNT_W),
      .OFS_COUNT(ADDR_W'(8'h10)), .OFS_RATIO(ADDR_W'(8'h14)), .OFS_FREEZE(ADDR_W'(8'h4c)),
      .RATIO_RESET(RATIO_RESET)
   ) u_regs (
      .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .count_i(usec_count), .bus_rdata(bus_rdata), .ratio_o(ratio_w),
      .freeze_o(frz_w), .ratio_wr_o(ratio_wr_w)
   );

   usec_accum #(.FIELD_W(FIELD_W), .USE_BORROW(USE_BORROW)) u_accum (
      .clk(clk), .rst(rst), .ratio_i(ratio_w), .freeze_i(frz_w), .clear_i(ratio_wr_w),
      .adv_o(adv_w), .tick_o(usec_tick), .acc_o(acc_w), .den_o(den_w)
   );

   usec_count #(.COUNT_W(COUNT_W), .LANE_W(LANE_W)) u_count (
      .clk(clk), .rst(rst), .inc_i(adv_w), .count_o(usec_count)
   );

endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk #(
   parameter int unsigned COUNT_W = 32,
   parameter int unsigned FIELD_W = 8
) (
   input logic               clk,
   input logic               rst,
   input logic               tick,
   input logic [COUNT_W-1:0] cnt,
   input logic [FIELD_W:0]   acc,
   input logic [FIELD_W:0]   den,
   input logic               frz,
   input logic               ratio_wr
);

   // R2 R3
   count_step_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(cnt) |-> cnt == COUNT_W'($past(cnt) + 1'b1));

   // R2
   tick_step_chk: assert property (@(posedge clk) disable iff (rst)
      tick |-> cnt == COUNT_W'($past(cnt) + 1'b1));

   // R5
   freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (frz && !ratio_wr) |=> ($stable(cnt) && $stable(acc) && !tick));

   // R6
   ratio_clear_chk: assert property (@(posedge clk) disable iff (rst)
      ratio_wr |=> (acc == '0 && !tick));

   // R2
   acc_range_chk: assert property (@(posedge clk) disable iff (rst)
      acc < den);

endmodule

bind usec_timebase usec_timebase_chk #(.COUNT_W(COUNT_W), .FIELD_W(FIELD_W)) u_chk (
   .clk(clk), .rst(rst), .tick(usec_tick), .cnt(usec_count), .acc(acc_w),
   .den(den_w), .frz(frz_w), .ratio_wr(ratio_wr_w)
);

// File: tb/usec_timebase_test.sv
module usec_timebase_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        we = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, n_rdata;
   logic        tick, n_tick;
   logic [31:0] cnt;
   logic [9:0]  n_cnt;

   always #5 clk = ~clk;

   usec_timebase uut (
      .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
      .bus_rdata(rdata), .usec_tick(tick), .usec_count(cnt)
   );

   usec_timebase #(.COUNT_W(10), .LANE_W(5), .USE_BORROW(1'b1)) uut_narrow (
      .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
      .bus_rdata(n_rdata), .usec_tick(n_tick), .usec_count(n_cnt)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // behavioural reference model
   int unsigned m_acc = 0, m_ratio = 32'h000b, m_cnt = 0;
   bit          m_frz = 0, m_tick = 0;
   bit          wrapped = 0;

   always @(posedge clk) begin
      if (rst) begin
         m_acc = 0; m_ratio = 32'h000b; m_cnt = 0; m_frz = 0; m_tick = 0;
      end else begin
         int unsigned num, den;
         bit old_frz;
         num = ((m_ratio >> 8) & 255) + 1;
         den = (m_ratio & 255) + 1;
         old_frz = m_frz;
         m_tick = 0;
         if (we && addr == 8'h14) begin
            m_acc = 0;
            m_ratio = wdata & 32'hffff;
         end else if (!old_frz) begin
            m_acc = m_acc + num;
            if (m_acc >= den) begin
               m_acc = m_acc - den;
               m_tick = 1;
               m_cnt = m_cnt + 1;
            end
         end
         if (we && addr == 8'h4c) m_frz = wdata[0];
      end
   end

   logic [9:0] prev_n = '0;
   always @(negedge clk) begin
      if (!rst && !done) begin
         check(tick == m_tick, "R2 tick", tick, m_tick);
         check(cnt == m_cnt, "R2 count", cnt, m_cnt);
         check(n_tick == m_tick, "R2 narrow tick", n_tick, m_tick);
         check(n_cnt == m_cnt[9:0], "R3 narrow count", n_cnt, m_cnt[9:0]);
         if (prev_n == 10'h3ff && n_cnt == 10'h000) wrapped = 1;
         prev_n = n_cnt;
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0; addr = 8'h00; wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
      addr = a;
      #1;
      check(rdata == exp, req, rdata, exp);
      if (a == 8'h10) check(rdata == cnt, "R8 port vs read", cnt, rdata);
      addr = 8'h00;
   endtask

   task automatic ratio_run(input logic [31:0] r, input int n);
      longint c0, expd;
      wr(8'h14, r);
      c0 = cnt;
      repeat (n) @(negedge clk);
      expd = (longint'(n) * (((r >> 8) & 255) + 1)) / ((r & 255) + 1);
      check(longint'(cnt) - c0 == expd, "R2 ratio rate", longint'(cnt) - c0, expd);
      rd(8'h10, cnt, "R4 count read");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      longint c0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      rd(8'h10, 32'h0, "R1 count");
      rd(8'h14, 32'h0000000b, "R1 ratio");
      rd(8'h4c, 32'h0, "R1 freeze");
      check(tick == 1'b0, "R1 tick", tick, 0);

      // R2 reference ratios
      ratio_run(32'h000b, 1200);
      ratio_run(32'h000c, 1300);
      ratio_run(32'h045f, 960);
      ratio_run(32'h0019, 2600);
      ratio_run(32'h045f, 97);

      // R4 register map
      wr(8'h14, 32'hdead045f);
      rd(8'h14, 32'h0000045f, "R4 ratio upper bits");
      rd(8'h20, 32'h0, "R4 unmapped read");

      // R5 freeze
      wr(8'h4c, 32'h1);
      rd(8'h4c, 32'h1, "R5 freeze read");
      c0 = cnt;
      repeat (500) @(negedge clk);
      check(cnt == c0, "R5 frozen count", cnt, c0);
      check(tick == 1'b0, "R5 frozen tick", tick, 0);

      // R7 ignored writes (while frozen)
      wr(8'h10, 32'h12345678);
      rd(8'h10, c0[31:0], "R7 count write ignored");
      wr(8'h20, 32'hffffffff);
      rd(8'h14, 32'h0000045f, "R7 ratio after unmapped write");
      rd(8'h4c, 32'h1, "R7 freeze after unmapped write");
      wr(8'h4c, 32'h0);
      repeat (200) @(negedge clk);
      check(cnt > c0, "R5 resume after freeze", cnt, c0 + 1);

      // R6 ratio write clears phase
      wr(8'h14, 32'h000b);
      repeat (5) @(negedge clk);
      wr(8'h14, 32'h000b);
      c0 = cnt;
      repeat (11) @(negedge clk);
      check(cnt == c0, "R6 no tick before 12th cycle", cnt, c0);
      @(negedge clk);
      check(cnt == c0 + 1, "R6 tick on 12th cycle", cnt, c0 + 1);

      // R3 wrap on the narrow instance
      wr(8'h14, 32'h0000);
      repeat (1100) @(negedge clk);
      check(wrapped == 1'b1, "R3 narrow wrap seen", wrapped, 1);
      check(n_cnt == cnt[9:0], "R3 narrow vs wide", n_cnt, cnt[9:0]);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule